// File: doc/BRIEF.md
# Cascaded Interrupt Pair with Vector Acknowledge

This block pairs two eight-line interrupt controllers. Together they serve sixteen request inputs. The upper controller (slave) forwards a winning request to line 2 of the lower controller (master). The forwarding is a one-cycle set pulse, so the master sees an edge on that line.

A 4-bit global request number selects the controller and the line. The block also holds one trigger-mode register per controller, and each register is filtered by a fixed mask. It decodes byte-wide port accesses to the two register pairs and to the two trigger-mode registers. On a CPU acknowledge strobe it returns an 8-bit vector. The vector is formed from the chosen controller's vector base and the winning line. If no request is waiting, line 7 is substituted as the spurious vector.

Each controller has the following behaviour:
- Fixed priority: line 0 is the highest.
- A request is raised only if it outranks every line already in service.
- The vector base is 5 bits wide and is loaded through a short init sequence.
- Lines can be masked.
- End-of-interrupt commands are supported.

Top module: `pic_cascade_ack`

## Requirements
- R1: A request strobe with global number `n` drives controller `n[3]`: 0 is the master and 1 is the slave. The line driven is `n[2:0]`.
- R2: A line in edge mode latches a request only on a rise of its level. While the level stays high after an acknowledge, no further request is latched.
- R3: A line in level mode has a request bit that follows its level. Acknowledge does not clear that bit.
- R4: Among unmasked pending lines, the lowest number wins. A line that is equal to or lower in priority than the highest-priority in-service line is held back. `int_o` is high exactly when the master has a winner, so masked lines never raise it.
- R5: A slave winner is registered into a cascade flag on the next edge. That flag sets master line 2 on the edge after. As a result, `int_o` rises on the second edge after the slave request becomes visible. An acknowledge that serves the slave leaves no stale cascade request.
- R6: An acknowledge strobe gives `vector_valid_o` high for exactly the next cycle. When the master winner is not line 2, `vector_o` is master base OR line. The winning line enters service, and in edge mode its request clears.
- R7: When the master winner is line 2, the slave is acknowledged as well. The vector is slave base OR slave line.
- R8: An acknowledge with no master winner returns master base OR 7 and changes no state.
- R9: When the master winner is line 2 but the slave has no winner, the vector is slave base OR 7.
- R10: Address 0x4D0 holds the master trigger-mode register and 0x4D1 holds the slave's (bit = 1 means level mode). Writes are ANDed with 0xF8 for the master and 0xDE for the slave, and the stored value reads back.
- R11: Addresses 0x20/0x21 reach the master and 0xA0/0xA1 reach the slave. The even address is the command register and the odd address is the mask register. An even read returns the request register, or the in-service register when that is selected. Command writes work as follows:
  - bit 4 set: clears mask and in-service, selects request readback, and arms the next odd write to load the vector base (data AND 0xF8).
  - bit 4 clear and bit 3 set: if bit 1 is set, bit 0 selects readback (1 = in-service).
- R12: An access whose length `io_len_i` is not 1 changes nothing and reads back zero.
- R13: An access to any address other than the six decoded ones changes nothing and reads back zero. Read data appears on `io_rdata_o` in the cycle after the read strobe.
- R14: A command write with bits 4 and 3 clear and bits 7:5 = 001 is a non-specific end of interrupt. It clears the highest-priority in-service bit. With bits 7:5 = 011 it is a specific end of interrupt, which clears in-service bit `data[2:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_set_i | input | 1 | Request level update strobe |
| irq_num_i | input | 4 | Global request number |
| irq_level_i | input | 1 | New level for the selected line |
| io_addr_i | input | 16 | Port address |
| io_len_i | input | 3 | Access length in bytes |
| io_wr_i | input | 1 | Port write strobe |
| io_rd_i | input | 1 | Port read strobe |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, one cycle after the strobe |
| ack_i | input | 1 | CPU acknowledge strobe |
| int_o | output | 1 | Interrupt request to the CPU |
| vector_o | output | 8 | Acknowledge vector |
| vector_valid_o | output | 1 | Vector valid, one cycle after acknowledge |

## Verification
The assertions check the following on every cycle:
- the one-cycle pairing of acknowledge and vector-valid;
- the line-7 substitution whenever the master had no winner;
- the slave vector on a cascaded acknowledge;
- the cascade flag following the slave winner;
- the zero readback of wrong-length reads.

Some behaviour can only be shown by the bench's directed scenarios:
- edge versus level latching;
- in-service blocking;
- masking;
- the two-edge cascade latency;
- the slave-spurious case built by masking the slave after forwarding;
- trigger-mask filtering;
- end-of-interrupt forms;
- the absence of effects from undecoded or wrong-length writes.

// File: rtl/pic_cascade_pkg.sv
package pic_cascade_pkg;
  localparam int LINES  = 8;
  localparam int LINE_W = $clog2(LINES);
  localparam int DATA_W = 8;

  localparam logic [DATA_W-1:0] MASTER_TRIG_MASK = 8'hF8;
  localparam logic [DATA_W-1:0] SLAVE_TRIG_MASK  = 8'hDE;

  localparam logic [2:0] CMD_NSEOI = 3'b001;
  localparam logic [2:0] CMD_SEOI  = 3'b011;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_CTL0,
    RD_CTL1,
    RD_TRIG
  } rd_src_e;
endpackage

// File: rtl/pic_line_ctrl.sv
module pic_line_ctrl
  import pic_cascade_pkg::*;
#(
  parameter int N  = LINES,
  parameter int DW = DATA_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_we_i,
  input  logic [$clog2(N)-1:0] req_line_i,
  input  logic                 req_level_i,
  input  logic [N-1:0]         pulse_i,
  input  logic [N-1:0]         trig_i,
  input  logic                 wr_i,
  input  logic                 reg_sel_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic                 ack_i,
  output logic                 win_valid_o,
  output logic [$clog2(N)-1:0] win_line_o,
  output logic [DW-1:0]        base_o,
  output logic [DW-1:0]        rdata_o
);
  localparam int LW = $clog2(N);
  localparam logic [DW-1:0] BASE_MASK = {DW{1'b1}} << LW;

  logic [N-1:0]  irr_q, irr_d, last_q, last_d, isr_q, isr_d, imr_q, imr_d;
  logic [DW-1:0] base_q, base_d;
  logic          arm_q, arm_d, rsel_q, rsel_d;
  logic [LW:0]   req_pick, isr_pick;

  function automatic logic [LW:0] lowest(input logic [N-1:0] v);
    logic [LW:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, LW'(i)};
    end
    return r;
  endfunction

  assign req_pick    = lowest(irr_q & ~imr_q);
  assign isr_pick    = lowest(isr_q);
  assign win_valid_o = req_pick[LW] && (!isr_pick[LW] || (req_pick[LW-1:0] < isr_pick[LW-1:0]));
  assign win_line_o  = req_pick[LW-1:0];
  assign base_o      = base_q;
  assign rdata_o     = reg_sel_i ? DW'(imr_q) : (rsel_q ? DW'(isr_q) : DW'(irr_q));

  always_comb begin
    irr_d  = irr_q;
    last_d = last_q;
    isr_d  = isr_q;
    imr_d  = imr_q;
    base_d = base_q;
    arm_d  = arm_q;
    rsel_d = rsel_q;
    if (req_we_i) begin
      if (trig_i[req_line_i]) irr_d[req_line_i] = req_level_i;
      else if (req_level_i && !last_q[req_line_i]) irr_d[req_line_i] = 1'b1;
      last_d[req_line_i] = req_level_i;
    end
    irr_d = irr_d | pulse_i;
    if (ack_i && win_valid_o) begin
      isr_d[win_line_o] = 1'b1;
      if (!trig_i[win_line_o]) irr_d[win_line_o] = 1'b0;
    end
    if (wr_i) begin
      if (!reg_sel_i) begin
        if (wdata_i[4]) begin
          imr_d  = '0;
          isr_d  = '0;
          arm_d  = 1'b1;
          rsel_d = 1'b0;
        end else if (wdata_i[3]) begin
          if (wdata_i[1]) rsel_d = wdata_i[0];
        end else if (wdata_i[7:5] == CMD_NSEOI) begin
          if (isr_pick[LW]) isr_d[isr_pick[LW-1:0]] = 1'b0;
        end else if (wdata_i[7:5] == CMD_SEOI) begin
          isr_d[wdata_i[LW-1:0]] = 1'b0;
        end
      end else if (arm_q) begin
        base_d = wdata_i & BASE_MASK;
        arm_d  = 1'b0;
      end else begin
        imr_d = wdata_i[N-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q  <= '0;
      last_q <= '0;
      isr_q  <= '0;
      imr_q  <= '0;
      base_q <= '0;
      arm_q  <= 1'b0;
      rsel_q <= 1'b0;
    end else begin
      irr_q  <= irr_d;
      last_q <= last_d;
      isr_q  <= isr_d;
      imr_q  <= imr_d;
      base_q <= base_d;
      arm_q  <= arm_d;
      rsel_q <= rsel_d;
    end
  end
endmodule

// File: rtl/pic_port_decode.sv
module pic_port_decode
  import pic_cascade_pkg::*;
#(
  parameter int              AW        = 16,
  parameter int              LEN_W     = 3,
  parameter logic [AW-1:0]   CTL0_ADDR = 16'h0020,
  parameter logic [AW-1:0]   CTL1_ADDR = 16'h00A0,
  parameter logic [AW-1:0]   TRIG_ADDR = 16'h04D0
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             wr_i,
  input  logic             rd_i,
  output logic [1:0]       ctl_wr_o,
  output logic [1:0]       trig_wr_o,
  output logic             reg_sel_o,
  output rd_src_e          rd_src_o
);
  logic byte_ok, hit_c0, hit_c1, hit_t, wr_ok, rd_ok;

  assign byte_ok   = (len_i == LEN_W'(1));
  assign hit_c0    = (addr_i[AW-1:1] == CTL0_ADDR[AW-1:1]);
  assign hit_c1    = (addr_i[AW-1:1] == CTL1_ADDR[AW-1:1]);
  assign hit_t     = (addr_i[AW-1:1] == TRIG_ADDR[AW-1:1]);
  assign wr_ok     = wr_i && byte_ok;
  assign rd_ok     = rd_i && byte_ok;
  assign reg_sel_o = addr_i[0];
  assign ctl_wr_o  = {hit_c1 && wr_ok, hit_c0 && wr_ok};
  assign trig_wr_o = {hit_t && wr_ok && addr_i[0], hit_t && wr_ok && !addr_i[0]};

  always_comb begin
    rd_src_o = RD_NONE;
    if (rd_ok) begin
      if (hit_c0)      rd_src_o = RD_CTL0;
      else if (hit_c1) rd_src_o = RD_CTL1;
      else if (hit_t)  rd_src_o = RD_TRIG;
    end
  end
endmodule

// File: rtl/pic_cascade_ack.sv
module pic_cascade_ack
  import pic_cascade_pkg::*;
#(
  parameter int            AW        = 16,
  parameter int            LEN_W     = 3,
  parameter int            CAS_LINE  = 2,
  parameter logic [AW-1:0] CTL0_ADDR = 16'h0020,
  parameter logic [AW-1:0] CTL1_ADDR = 16'h00A0,
  parameter logic [AW-1:0] TRIG_ADDR = 16'h04D0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               irq_set_i,
  input  logic [LINE_W:0]    irq_num_i,
  input  logic               irq_level_i,
  input  logic [AW-1:0]      io_addr_i,
  input  logic [LEN_W-1:0]   io_len_i,
  input  logic               io_wr_i,
  input  logic               io_rd_i,
  input  logic [DATA_W-1:0]  io_wdata_i,
  output logic [DATA_W-1:0]  io_rdata_o,
  input  logic               ack_i,
  output logic               int_o,
  output logic [DATA_W-1:0]  vector_o,
  output logic               vector_valid_o
);
  localparam int N  = LINES;
  localparam int LW = LINE_W;
  localparam int DW = DATA_W;
  localparam logic [LW-1:0] CAS  = LW'(CAS_LINE);
  localparam logic [LW-1:0] SPUR = LW'(N - 1);
  localparam logic [1:0][DW-1:0] TRIG_MASKS = {SLAVE_TRIG_MASK, MASTER_TRIG_MASK};

  logic [1:0]          ctl_wr, trig_wr, ctl_ack, win_valid;
  logic                reg_sel;
  rd_src_e             rd_src;
  logic [1:0][DW-1:0]  trig_q, base, ctl_rdata;
  logic [1:0][N-1:0]   pulse;
  logic [1:0][LW-1:0]  win_line;
  logic                m_valid, s_valid, s_ack, cas_q, vec_valid_q;
  logic [LW-1:0]       m_line, s_line;
  logic [DW-1:0]       m_base, s_base, vec_d, vector_q, rd_mux, rdata_q;

  pic_port_decode #(
    .AW(AW), .LEN_W(LEN_W), .CTL0_ADDR(CTL0_ADDR), .CTL1_ADDR(CTL1_ADDR), .TRIG_ADDR(TRIG_ADDR)
  ) i_decode (
    .addr_i   (io_addr_i),
    .len_i    (io_len_i),
    .wr_i     (io_wr_i),
    .rd_i     (io_rd_i),
    .ctl_wr_o (ctl_wr),
    .trig_wr_o(trig_wr),
    .reg_sel_o(reg_sel),
    .rd_src_o (rd_src)
  );

  assign m_valid = win_valid[0];
  assign m_line  = win_line[0];
  assign m_base  = base[0];
  assign s_valid = win_valid[1];
  assign s_line  = win_line[1];
  assign s_base  = base[1];
  assign s_ack   = ack_i && m_valid && (m_line == CAS);
  assign ctl_ack = {s_ack, ack_i};
  assign pulse[0] = N'(cas_q) << CAS_LINE;
  assign pulse[1] = '0;

  for (genvar c = 0; c < 2; c++) begin : g_ctl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         trig_q[c] <= '0;
      else if (trig_wr[c]) trig_q[c] <= io_wdata_i & TRIG_MASKS[c];
    end

    pic_line_ctrl #(.N(N), .DW(DW)) i_ctl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_we_i   (irq_set_i && (irq_num_i[LW] == 1'(c))),
      .req_line_i (irq_num_i[LW-1:0]),
      .req_level_i(irq_level_i),
      .pulse_i    (pulse[c]),
      .trig_i     (trig_q[c][N-1:0]),
      .wr_i       (ctl_wr[c]),
      .reg_sel_i  (reg_sel),
      .wdata_i    (io_wdata_i),
      .ack_i      (ctl_ack[c]),
      .win_valid_o(win_valid[c]),
      .win_line_o (win_line[c]),
      .base_o     (base[c]),
      .rdata_o    (ctl_rdata[c])
    );
  end

  always_comb begin
    if (!m_valid)          vec_d = m_base | DW'(SPUR);
    else if (m_line == CAS) vec_d = s_valid ? (s_base | DW'(s_line)) : (s_base | DW'(SPUR));
    else                    vec_d = m_base | DW'(m_line);
  end

  always_comb begin
    case (rd_src)
      RD_CTL0: rd_mux = ctl_rdata[0];
      RD_CTL1: rd_mux = ctl_rdata[1];
      RD_TRIG: rd_mux = trig_q[reg_sel];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vector_q    <= '0;
      vec_valid_q <= 1'b0;
      cas_q       <= 1'b0;
      rdata_q     <= '0;
    end else begin
      if (ack_i) vector_q <= vec_d;
      vec_valid_q <= ack_i;
      // a slave served by this acknowledge must not be re-forwarded
      cas_q       <= s_valid && !s_ack;
      rdata_q     <= rd_mux;
    end
  end

  assign int_o          = m_valid;
  assign vector_o       = vector_q;
  assign vector_valid_o = vec_valid_q;
  assign io_rdata_o     = rdata_q;
endmodule

// File: rtl/pic_cascade_ack_chk.sv
module pic_cascade_ack_chk #(
  parameter int DW       = 8,
  parameter int LW       = 3,
  parameter int LEN_W    = 3,
  parameter int CAS_LINE = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ack_i,
  input logic             io_rd_i,
  input logic [LEN_W-1:0] io_len_i,
  input logic [DW-1:0]    io_rdata_o,
  input logic             int_o,
  input logic [DW-1:0]    vector_o,
  input logic             vector_valid_o,
  input logic             m_valid,
  input logic [LW-1:0]    m_line,
  input logic             s_valid,
  input logic [LW-1:0]    s_line,
  input logic [DW-1:0]    s_base,
  input logic             cas_q
);
  // R6
  ack_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) ack_i |=> vector_valid_o);
  // R6
  no_ack_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !ack_i |=> !vector_valid_o);
  // R8
  spur_master_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !int_o) |=> (vector_o[LW-1:0] == {LW{1'b1}}));
  // R7
  slave_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && m_valid && (m_line == LW'(CAS_LINE)) && s_valid) |=> (vector_o == $past(s_base | DW'(s_line))));
  // R5
  cas_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) (s_valid && !ack_i) |=> cas_q);
  // R5
  cas_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !s_valid |=> !cas_q);
  // R12
  bad_len_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && (io_len_i != LEN_W'(1))) |=> (io_rdata_o == '0));
endmodule

bind pic_cascade_ack pic_cascade_ack_chk #(
  .DW(DW), .LW(LW), .LEN_W(LEN_W), .CAS_LINE(CAS_LINE)
) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ack_i         (ack_i),
  .io_rd_i       (io_rd_i),
  .io_len_i      (io_len_i),
  .io_rdata_o    (io_rdata_o),
  .int_o         (int_o),
  .vector_o      (vector_o),
  .vector_valid_o(vector_valid_o),
  .m_valid       (m_valid),
  .m_line        (m_line),
  .s_valid       (s_valid),
  .s_line        (s_line),
  .s_base        (s_base),
  .cas_q         (cas_q)
);

// File: tb/test_pic_cascade_ack.sv
module test_pic_cascade_ack;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       irq_set_i = 1'b0;
  logic [3:0] irq_num_i = '0;
  logic       irq_level_i = 1'b0;
  logic [15:0] io_addr_i = '0;
  logic [2:0] io_len_i = 3'd1;
  logic       io_wr_i = 1'b0;
  logic       io_rd_i = 1'b0;
  logic [7:0] io_wdata_i = '0;
  logic [7:0] io_rdata_o;
  logic       ack_i = 1'b0;
  logic       int_o;
  logic [7:0] vector_o;
  logic       vector_valid_o;

  int errors = 0;
  int checks = 0;
  logic [7:0] rd;
  logic [7:0] vec;
  logic       vv;

  pic_cascade_ack i_pic_cascade_ack (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_set_i(irq_set_i), .irq_num_i(irq_num_i),
    .irq_level_i(irq_level_i), .io_addr_i(io_addr_i), .io_len_i(io_len_i),
    .io_wr_i(io_wr_i), .io_rd_i(io_rd_i), .io_wdata_i(io_wdata_i), .io_rdata_o(io_rdata_o),
    .ack_i(ack_i), .int_o(int_o), .vector_o(vector_o), .vector_valid_o(vector_valid_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic set_irq(input logic [3:0] n, input logic lvl);
    @(negedge clk_i);
    irq_set_i = 1'b1; irq_num_i = n; irq_level_i = lvl;
    @(negedge clk_i);
    irq_set_i = 1'b0;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d, input logic [2:0] len = 3'd1);
    @(negedge clk_i);
    io_addr_i = a; io_wdata_i = d; io_len_i = len; io_wr_i = 1'b1;
    @(negedge clk_i);
    io_wr_i = 1'b0; io_len_i = 3'd1;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d, input logic [2:0] len = 3'd1);
    @(negedge clk_i);
    io_addr_i = a; io_len_i = len; io_rd_i = 1'b1;
    @(negedge clk_i);
    io_rd_i = 1'b0; io_len_i = 3'd1;
    d = io_rdata_o;
  endtask

  task automatic do_ack(output logic [7:0] v, output logic valid);
    @(negedge clk_i);
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
    v = vector_o;
    valid = vector_valid_o;
  endtask

  task automatic t_reset;
    chk("R6", "int after reset", {7'd0, int_o}, 8'h00);
    chk("R6", "valid after reset", {7'd0, vector_valid_o}, 8'h00);
    io_read(16'h0020, rd);
    chk("R11", "master request after reset", rd, 8'h00);
  endtask

  task automatic t_init;
    io_write(16'h0020, 8'h10);
    io_write(16'h0021, 8'h08);
    io_write(16'h00A0, 8'h10);
    io_write(16'h00A1, 8'h75);
    io_read(16'h0021, rd);
    chk("R11", "master mask after init", rd, 8'h00);
  endtask

  task automatic t_edge;
    set_irq(4'd3, 1'b1);
    chk("R1", "master line 3 raises int", {7'd0, int_o}, 8'h01);
    do_ack(vec, vv);
    chk("R6", "valid pulse", {7'd0, vv}, 8'h01);
    chk("R6", "master vector line 3", vec, 8'h0B);
    @(negedge clk_i);
    chk("R6", "valid drops", {7'd0, vector_valid_o}, 8'h00);
    set_irq(4'd3, 1'b1);
    io_read(16'h0020, rd);
    chk("R2", "held level relatches nothing", rd, 8'h00);
    io_write(16'h0020, 8'h20);
    chk("R2", "no int after eoi", {7'd0, int_o}, 8'h00);
    set_irq(4'd3, 1'b0);
    set_irq(4'd3, 1'b1);
    chk("R2", "new rise latches", {7'd0, int_o}, 8'h01);
    do_ack(vec, vv);
    chk("R2", "vector on second rise", vec, 8'h0B);
    io_write(16'h0020, 8'h20);
    set_irq(4'd3, 1'b0);
  endtask

  task automatic t_priority;
    set_irq(4'd5, 1'b1);
    set_irq(4'd4, 1'b1);
    do_ack(vec, vv);
    chk("R4", "lower number wins", vec, 8'h0C);
    chk("R4", "line 5 blocked by service", {7'd0, int_o}, 8'h00);
    io_write(16'h0020, 8'h20);
    chk("R4", "line 5 after eoi", {7'd0, int_o}, 8'h01);
    do_ack(vec, vv);
    chk("R4", "vector line 5", vec, 8'h0D);
    io_write(16'h0020, 8'h20);
    set_irq(4'd4, 1'b0);
    set_irq(4'd5, 1'b0);
    io_write(16'h0021, 8'h40);
    set_irq(4'd6, 1'b1);
    chk("R4", "masked line silent", {7'd0, int_o}, 8'h00);
    io_write(16'h0021, 8'h00);
    chk("R4", "unmasked line raises", {7'd0, int_o}, 8'h01);
    do_ack(vec, vv);
    chk("R4", "vector line 6", vec, 8'h0E);
    io_write(16'h0020, 8'h20);
    set_irq(4'd6, 1'b0);
  endtask

  task automatic t_trig_level;
    io_write(16'h04D0, 8'hFF);
    io_read(16'h04D0, rd);
    chk("R10", "master trigger mask", rd, 8'hF8);
    io_write(16'h04D1, 8'hFF);
    io_read(16'h04D1, rd);
    chk("R10", "slave trigger mask", rd, 8'hDE);
    set_irq(4'd3, 1'b1);
    do_ack(vec, vv);
    chk("R3", "level vector", vec, 8'h0B);
    io_read(16'h0020, rd);
    chk("R3", "level request kept after ack", rd, 8'h08);
    io_write(16'h0020, 8'h20);
    chk("R3", "level re-requests after eoi", {7'd0, int_o}, 8'h01);
    set_irq(4'd3, 1'b0);
    chk("R3", "level low clears request", {7'd0, int_o}, 8'h00);
    io_write(16'h04D0, 8'h00);
    io_write(16'h04D1, 8'h00);
  endtask

  task automatic t_cascade;
    set_irq(4'd12, 1'b1);
    chk("R5", "no int at slave edge", {7'd0, int_o}, 8'h00);
    @(negedge clk_i);
    chk("R5", "no int one edge later", {7'd0, int_o}, 8'h00);
    @(negedge clk_i);
    chk("R5", "int on second edge", {7'd0, int_o}, 8'h01);
    do_ack(vec, vv);
    chk("R7", "slave vector line 4", vec, 8'h74);
    @(negedge clk_i);
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R5", "no stale cascade", {7'd0, int_o}, 8'h00);
    io_write(16'h00A0, 8'h20);
    io_write(16'h0020, 8'h20);
    set_irq(4'd12, 1'b0);
    chk("R1", "slave line 4 only", {7'd0, int_o}, 8'h00);
  endtask

  task automatic t_spur_slave;
    set_irq(4'd13, 1'b1);
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R9", "cascade int", {7'd0, int_o}, 8'h01);
    io_write(16'h00A1, 8'h20);
    do_ack(vec, vv);
    chk("R9", "slave spurious vector", vec, 8'h77);
    io_write(16'h0020, 8'h20);
    io_write(16'h00A1, 8'h00);
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R9", "pending slave forwarded again", {7'd0, int_o}, 8'h01);
    do_ack(vec, vv);
    chk("R7", "slave vector line 5", vec, 8'h75);
    io_write(16'h00A0, 8'h20);
    io_write(16'h0020, 8'h20);
    set_irq(4'd13, 1'b0);
  endtask

  task automatic t_spur_master;
    do_ack(vec, vv);
    chk("R8", "master spurious vector", vec, 8'h0F);
    io_write(16'h0020, 8'h0B);
    io_read(16'h0020, rd);
    chk("R8", "no service after spurious", rd, 8'h00);
    io_write(16'h0020, 8'h0A);
  endtask

  task automatic t_eoi;
    set_irq(4'd6, 1'b1);
    do_ack(vec, vv);
    chk("R14", "vector line 6", vec, 8'h0E);
    set_irq(4'd1, 1'b1);
    do_ack(vec, vv);
    chk("R14", "nested vector line 1", vec, 8'h09);
    io_write(16'h0020, 8'h0B);
    io_read(16'h0020, rd);
    chk("R14", "in-service both", rd, 8'h42);
    io_write(16'h0020, 8'h66);
    io_read(16'h0020, rd);
    chk("R14", "specific eoi line 6", rd, 8'h02);
    io_write(16'h0020, 8'h20);
    io_read(16'h0020, rd);
    chk("R14", "non-specific eoi", rd, 8'h00);
    io_write(16'h0020, 8'h0A);
    set_irq(4'd1, 1'b0);
    set_irq(4'd6, 1'b0);
  endtask

  task automatic t_bad_len;
    io_write(16'h0021, 8'hFF, 3'd2);
    io_read(16'h0021, rd);
    chk("R12", "wide write ignored", rd, 8'h00);
    io_write(16'h04D0, 8'hFF, 3'd0);
    io_read(16'h04D0, rd);
    chk("R12", "zero length write ignored", rd, 8'h00);
    io_write(16'h0021, 8'h55);
    io_read(16'h0021, rd, 3'd4);
    chk("R12", "wide read zero", rd, 8'h00);
    io_read(16'h0021, rd);
    chk("R12", "byte read mask", rd, 8'h55);
    io_write(16'h0021, 8'h00);
  endtask

  task automatic t_undecoded;
    io_write(16'h0022, 8'hFF);
    io_write(16'h04D2, 8'hFF);
    io_write(16'h01A1, 8'hFF);
    io_read(16'h0021, rd);
    chk("R13", "master mask untouched", rd, 8'h00);
    io_read(16'h00A1, rd);
    chk("R13", "slave mask untouched", rd, 8'h00);
    io_read(16'h04D0, rd);
    chk("R13", "trigger untouched", rd, 8'h00);
    io_read(16'h0022, rd);
    chk("R13", "undecoded read zero", rd, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_init();
    t_edge();
    t_priority();
    t_trig_level();
    t_cascade();
    t_spur_slave();
    t_spur_master();
    t_eoi();
    t_bad_len();
    t_undecoded();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule